// File: doc/BRIEF.md
# Integer HINT Classifier

This block looks at one 32-bit base-integer instruction word per cycle and reports, one clock later, whether that word is the canonical NOP, the PAUSE hint, a HINT in the standard-reserved space, a HINT in the custom space, or none of these. A HINT is a word that must leave all architectural state alone apart from advancing the pc and any performance counters. A simple core can therefore retire such a word without touching the register file or memory ordering, and it can count retired HINTs by class.

Two families of encodings are recognised. The first is integer computational instructions that write register zero. The second is memory-fence encodings whose ordering sets leave nothing to order. The fence family is split further by which of the destination and source register fields are zero, and the one write-only-predecessor form is picked out as PAUSE. The argument fields a HINT carries are passed out next to the flags.

A new word may be presented every cycle. The result appears with its own valid strobe exactly one cycle after the input strobe.

Top module: `hint_classifier`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. A synchronous active-high `rst` clears `out_valid` and every flag and argument output.
- R2: When `out_valid` is high, exactly one of `is_nop`, `is_pause`, `is_std_hint`, `is_custom_hint` and `is_other` is high, and `no_side_effect` is the inverse of `is_other`. When `out_valid` is low, all flags and arguments are zero.
- R3: `is_nop` is raised for the word 0x00000013 only, which is ADDI with rd, rs1 and the immediate all zero.
- R4: With rd (bits 11:7) zero, the following raise `is_std_hint`: LUI (opcode 0x37), AUIPC (0x17), ADDI other than the NOP, XORI, ORI, ANDI (opcode 0x13, funct3 0/4/6/7), and ADD, SUB, SLL, XOR, SRL, SRA, OR, AND (opcode 0x33 with a legal funct7).
- R5: With rd zero, the following raise `is_custom_hint`: SLTI and SLTIU (funct3 2/3), SLLI (funct3 1, funct7 0), SRLI and SRAI (funct3 5, funct7 0x00 or 0x20), and SLT and SLTU (opcode 0x33, funct7 0, funct3 2/3).
- R6: A fence word (opcode 0x0F, funct3 0) with fm (bits 31:28) zero, pred (bits 27:24) or succ (bits 23:20) zero, and at most one nonzero register field among rd and rs1 (bits 19:15) raises both `is_fence_hint` and `is_std_hint`, unless it is PAUSE. With one register field fixed at a nonzero value, each of the two one-nonzero forms takes 31 pred/succ pairs (31 × 31 = 2^10 − 63 code points). With both register fields zero, 15 words have pred zero and succ nonzero, and 15 have succ zero and pred other than 0b0001.
- R7: `is_pause` is raised for the word 0x0100000F only (fm 0, pred 0b0001, succ 0, rd and rs1 zero), and that word raises no HINT flag.
- R8: `is_other` is raised for any other word: fences with nonzero fm, with both sets non-null, or with both rd and rs1 nonzero; unknown opcodes or illegal funct7 values; and every computational word with rd nonzero.
- R9: For a fence HINT, `arg_rd`, `arg_rs1` and `arg_succ` carry bits 11:7, 19:15 and 23:20, and `arg_rs2` is zero. For an opcode-0x33 HINT, `arg_rs1` and `arg_rs2` carry bits 19:15 and 24:20, and the others are zero. For every other word, all four are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word strobe |
| in_insn | input | 32 | Instruction word |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| is_nop | output | 1 | Canonical NOP |
| is_pause | output | 1 | PAUSE hint |
| is_std_hint | output | 1 | HINT in the standard-reserved space |
| is_custom_hint | output | 1 | HINT in the custom space |
| is_fence_hint | output | 1 | HINT carried in a fence encoding |
| is_other | output | 1 | Neither NOP, PAUSE nor HINT |
| no_side_effect | output | 1 | Word may retire without state change |
| arg_rs1 | output | 5 | First HINT argument register field |
| arg_rs2 | output | 5 | Second argument field of a register-register HINT |
| arg_rd | output | 5 | Destination field of a fence HINT |
| arg_succ | output | 4 | Successor set of a fence HINT |

## Verification
The properties assume that `in_valid` is low during reset. They also assume that `in_insn` is stable at each sampling edge whenever `in_valid` is high, so a result can be related to the word captured one edge earlier. The stimulus meets both assumptions. It drives inputs only on falling edges and holds the strobe low until reset is released. It then mixes an exhaustive fence sweep over fm, pred, succ and four register-zero patterns with opcode-biased random words, directed corner words and idle gaps.

// File: rtl/hint_pkg.sv
package hint_pkg;
  localparam int unsigned ILEN   = 32;
  localparam int unsigned REGW   = 5;
  localparam int unsigned SETW   = 4;
  localparam int unsigned OPW    = 7;
  localparam int unsigned F3W    = 3;
  localparam int unsigned F7W    = 7;

  localparam logic [OPW-1:0] OPC_LUI   = 7'h37;
  localparam logic [OPW-1:0] OPC_AUIPC = 7'h17;
  localparam logic [OPW-1:0] OPC_IMM   = 7'h13;
  localparam logic [OPW-1:0] OPC_REG   = 7'h33;
  localparam logic [OPW-1:0] OPC_FENCE = 7'h0F;

  localparam logic [F7W-1:0] F7_BASE = 7'h00;
  localparam logic [F7W-1:0] F7_ALT  = 7'h20;

  localparam logic [SETW-1:0] SET_W_ONLY = 4'b0001;

  typedef struct packed {
    logic nop;
    logic pause;
    logic std_hint;
    logic custom_hint;
    logic fence_hint;
    logic other;
    logic no_side_effect;
  } hint_flags_t;

  typedef struct packed {
    logic [REGW-1:0] rs1;
    logic [REGW-1:0] rs2;
    logic [REGW-1:0] rd;
    logic [SETW-1:0] succ;
  } hint_args_t;
endpackage

// File: rtl/hint_int_decode.sv
module hint_int_decode
  import hint_pkg::*;
(
  input  logic [ILEN-1:0] insn,
  output logic            nop,
  output logic            std_hint,
  output logic            custom_hint,
  output logic            reg_form
);
  logic [OPW-1:0] opc;
  logic [F3W-1:0] f3;
  logic [F7W-1:0] f7;
  logic           rd_zero;
  logic           upper_zero;

  assign opc        = insn[OPW-1:0];
  assign f3         = insn[14:12];
  assign f7         = insn[ILEN-1:ILEN-F7W];
  assign rd_zero    = (insn[11:7] == '0);
  assign upper_zero = (insn[ILEN-1:15] == '0);

  always_comb begin
    nop         = 1'b0;
    std_hint    = 1'b0;
    custom_hint = 1'b0;
    reg_form    = 1'b0;
    if (rd_zero) begin
      unique case (opc)
        OPC_LUI, OPC_AUIPC: std_hint = 1'b1;
        OPC_IMM: begin
          unique case (f3)
            3'd0: begin
              nop      = upper_zero;
              std_hint = !upper_zero;
            end
            3'd4, 3'd6, 3'd7: std_hint = 1'b1;
            3'd2, 3'd3:       custom_hint = 1'b1;
            3'd1:             custom_hint = (f7 == F7_BASE);
            3'd5:             custom_hint = (f7 == F7_BASE) || (f7 == F7_ALT);
            default:          custom_hint = 1'b0;
          endcase
        end
        OPC_REG: begin
          if (f7 == F7_BASE) begin
            custom_hint = (f3 == 3'd2) || (f3 == 3'd3);
            std_hint    = !custom_hint;
          end else if (f7 == F7_ALT) begin
            std_hint = (f3 == 3'd0) || (f3 == 3'd5);
          end
          reg_form = std_hint || custom_hint;
        end
        default: std_hint = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/hint_fence_decode.sv
module hint_fence_decode
  import hint_pkg::*;
(
  input  logic [ILEN-1:0] insn,
  output logic            pause,
  output logic            fence_hint
);
  logic            is_fence;
  logic [SETW-1:0] fm;
  logic [SETW-1:0] pred;
  logic [SETW-1:0] succ;
  logic            rd_zero;
  logic            rs1_zero;
  logic            null_set;
  logic            base_ok;

  assign is_fence = (insn[OPW-1:0] == OPC_FENCE) && (insn[14:12] == '0);
  assign fm       = insn[31:28];
  assign pred     = insn[27:24];
  assign succ     = insn[23:20];
  assign rd_zero  = (insn[11:7] == '0);
  assign rs1_zero = (insn[19:15] == '0);
  assign null_set = (pred == '0) || (succ == '0);

  always_comb begin
    base_ok    = is_fence && (fm == '0) && null_set && (rd_zero || rs1_zero);
    pause      = base_ok && rd_zero && rs1_zero && (pred == SET_W_ONLY) && (succ == '0);
    fence_hint = base_ok && !pause;
  end
endmodule

// File: rtl/hint_arg_select.sv
module hint_arg_select
  import hint_pkg::*;
(
  input  logic [ILEN-1:0] insn,
  input  logic            fence_hint,
  input  logic            reg_form,
  output hint_args_t      args
);
  always_comb begin
    args = '0;
    if (fence_hint) begin
      args.rs1  = insn[19:15];
      args.rd   = insn[11:7];
      args.succ = insn[23:20];
    end else if (reg_form) begin
      args.rs1 = insn[19:15];
      args.rs2 = insn[24:20];
    end
  end
endmodule

// File: rtl/hint_classifier.sv
module hint_classifier
  import hint_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [ILEN-1:0] in_insn,
  output logic            out_valid,
  output logic            is_nop,
  output logic            is_pause,
  output logic            is_std_hint,
  output logic            is_custom_hint,
  output logic            is_fence_hint,
  output logic            is_other,
  output logic            no_side_effect,
  output logic [REGW-1:0] arg_rs1,
  output logic [REGW-1:0] arg_rs2,
  output logic [REGW-1:0] arg_rd,
  output logic [SETW-1:0] arg_succ
);
  logic        int_nop, int_std, int_custom, int_reg;
  logic        f_pause, f_hint;
  hint_flags_t flags_d, flags_q;
  hint_args_t  args_d, args_q;

  hint_int_decode u_int (
    .insn        (in_insn),
    .nop         (int_nop),
    .std_hint    (int_std),
    .custom_hint (int_custom),
    .reg_form    (int_reg)
  );

  hint_fence_decode u_fence (
    .insn       (in_insn),
    .pause      (f_pause),
    .fence_hint (f_hint)
  );

  hint_arg_select u_args (
    .insn       (in_insn),
    .fence_hint (f_hint),
    .reg_form   (int_reg),
    .args       (args_d)
  );

  always_comb begin
    flags_d.nop            = int_nop;
    flags_d.pause          = f_pause;
    flags_d.std_hint       = int_std || f_hint;
    flags_d.custom_hint    = int_custom;
    flags_d.fence_hint     = f_hint;
    flags_d.no_side_effect = int_nop || f_pause || int_std || f_hint || int_custom;
    flags_d.other          = !flags_d.no_side_effect;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      flags_q   <= '0;
      args_q    <= '0;
    end else begin
      out_valid <= in_valid;
      flags_q   <= in_valid ? flags_d : '0;
      args_q    <= in_valid ? args_d  : '0;
    end
  end

  assign is_nop         = flags_q.nop;
  assign is_pause       = flags_q.pause;
  assign is_std_hint    = flags_q.std_hint;
  assign is_custom_hint = flags_q.custom_hint;
  assign is_fence_hint  = flags_q.fence_hint;
  assign is_other       = flags_q.other;
  assign no_side_effect = flags_q.no_side_effect;
  assign arg_rs1        = args_q.rs1;
  assign arg_rs2        = args_q.rs2;
  assign arg_rd         = args_q.rd;
  assign arg_succ       = args_q.succ;
endmodule

// File: rtl/hint_classifier_chk.sv
module hint_classifier_chk
  import hint_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [ILEN-1:0] in_insn,
  input logic            out_valid,
  input logic            is_nop,
  input logic            is_pause,
  input logic            is_std_hint,
  input logic            is_custom_hint,
  input logic            is_fence_hint,
  input logic            is_other,
  input logic            no_side_effect,
  input logic [REGW-1:0] arg_rs1,
  input logic [REGW-1:0] arg_rs2,
  input logic [REGW-1:0] arg_rd,
  input logic [SETW-1:0] arg_succ
);
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_drop_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_one_class_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones({is_nop, is_pause, is_std_hint, is_custom_hint, is_other}) == 1));
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ({is_nop, is_pause, is_std_hint, is_custom_hint, is_fence_hint,
                     is_other, no_side_effect, arg_rs1, arg_rs2, arg_rd, arg_succ} == '0));
  p_effect_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (no_side_effect != is_other));

  p_nop_word_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (is_nop == ($past(in_insn) == 32'h0000_0013)));

  p_fence_std_r6: assert property (@(posedge clk) disable iff (rst)
    is_fence_hint |-> (is_std_hint && (arg_rd == '0 || arg_rs1 == '0)));

  p_pause_word_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (is_pause == ($past(in_insn) == 32'h0100_000F)));

  p_quiet_args_r9: assert property (@(posedge clk) disable iff (rst)
    (is_other || is_nop || is_pause) |-> ({arg_rs1, arg_rs2, arg_rd, arg_succ} == '0));
endmodule

bind hint_classifier hint_classifier_chk u_chk (.*);

// File: tb/hint_classifier_bench.sv
module hint_classifier_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_insn = '0;
  logic        out_valid, is_nop, is_pause, is_std_hint, is_custom_hint;
  logic        is_fence_hint, is_other, no_side_effect;
  logic [4:0]  arg_rs1, arg_rs2, arg_rd;
  logic [3:0]  arg_succ;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  hint_classifier u_hint_classifier (.*);

  // expected {nop, pause, std, custom, fence, other, no_side_effect}
  function automatic logic [6:0] exp_flags(input logic [31:0] w);
    logic nop, pse, sh, ch, fh;
    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;
    nop = 0; pse = 0; sh = 0; ch = 0; fh = 0;
    opc = w[6:0]; f3 = w[14:12]; f7 = w[31:25];
    if (w == 32'h0000_0013) nop = 1;
    else if (w == 32'h0100_000F) pse = 1;
    else if (opc == 7'h0F) begin
      if (f3 == 0 && w[31:28] == 0 && (w[27:24] == 0 || w[23:20] == 0) &&
          (w[11:7] == 0 || w[19:15] == 0)) begin
        fh = 1; sh = 1;
      end
    end else if (w[11:7] == 0) begin
      if (opc == 7'h37 || opc == 7'h17) sh = 1;
      else if (opc == 7'h13) begin
        if (f3 inside {3'd0, 3'd4, 3'd6, 3'd7}) sh = 1;
        else if (f3 inside {3'd2, 3'd3}) ch = 1;
        else if (f3 == 3'd1) ch = (f7 == 7'h00);
        else ch = (f7 == 7'h00 || f7 == 7'h20);
      end else if (opc == 7'h33) begin
        if (f7 == 7'h00) begin
          ch = (f3 == 3'd2 || f3 == 3'd3);
          sh = !ch;
        end else if (f7 == 7'h20) sh = (f3 == 3'd0 || f3 == 3'd5);
      end
    end
    return {nop, pse, sh, ch, fh, !(nop | pse | sh | ch), (nop | pse | sh | ch)};
  endfunction

  function automatic logic [18:0] exp_args(input logic [31:0] w);
    logic [6:0] f;
    f = exp_flags(w);
    if (f[2]) return {w[19:15], 5'd0, w[11:7], w[23:20]};
    if (w[6:0] == 7'h33 && (f[4] || f[3])) return {w[19:15], w[24:20], 5'd0, 4'd0};
    return '0;
  endfunction

  function automatic string tag_of(input logic [31:0] w);
    logic [6:0] f;
    f = exp_flags(w);
    if (f[6]) return "R3";
    if (f[5]) return "R7";
    if (f[2]) return "R6";
    if (f[4]) return "R4";
    if (f[3]) return "R5";
    return "R8";
  endfunction

  task automatic check_now(input logic [31:0] w, input string tag);
    logic [6:0]  gf, ef;
    logic [18:0] ga, ea;
    gf = {is_nop, is_pause, is_std_hint, is_custom_hint, is_fence_hint, is_other, no_side_effect};
    ga = {arg_rs1, arg_rs2, arg_rd, arg_succ};
    ef = exp_flags(w);
    ea = exp_args(w);
    checks++;
    if (!out_valid || gf != ef) begin
      fails++;
      $display("FAIL %s word %h: valid %b flags %b, expected valid 1 flags %b", tag, w, out_valid, gf, ef);
    end else if (ga != ea) begin
      fails++;
      $display("FAIL R9 word %h: args %h, expected %h", w, ga, ea);
    end
  endtask

  task automatic send(input logic [31:0] w);
    in_valid = 1'b1;
    in_insn  = w;
    @(negedge clk);
    check_now(w, tag_of(w));
  endtask

  task automatic idle_check();
    in_valid = 1'b0;
    in_insn  = 32'hFFFF_FFFF;
    @(negedge clk);
    checks++;
    if (out_valid || {is_nop, is_pause, is_std_hint, is_custom_hint, is_fence_hint,
                      is_other, no_side_effect, arg_rs1, arg_rs2, arg_rd, arg_succ} != '0) begin
      fails++;
      $display("FAIL R2 idle: valid %b nop %b other %b, expected all 0", out_valid, is_nop, is_other);
    end
  endtask

  task automatic expect_count(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s count %0d, expected %0d", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] rand_word();
    logic [31:0] w;
    int sel;
    w = $urandom;
    sel = $urandom_range(0, 6);
    case (sel)
      0: w[6:0] = 7'h37;
      1: w[6:0] = 7'h17;
      2: w[6:0] = 7'h13;
      3: begin
        w[6:0] = 7'h33;
        case ($urandom_range(0, 2))
          0: w[31:25] = 7'h00;
          1: w[31:25] = 7'h20;
          default: ;
        endcase
      end
      4: begin
        w[6:0] = 7'h0F;
        if ($urandom_range(0, 3) != 0) w[14:12] = 3'd0;
        if ($urandom_range(0, 3) != 0) w[31:28] = 4'd0;
        if ($urandom_range(0, 1) != 0) w[27:24] = 4'd0;
        else if ($urandom_range(0, 1) != 0) w[23:20] = 4'd0;
        if ($urandom_range(0, 1) != 0) w[19:15] = 5'd0;
      end
      5: begin
        w[6:0] = 7'h13;
        w[14:12] = 3'd0;
        if ($urandom_range(0, 1) != 0) w[31:15] = '0;
      end
      default: ;
    endcase
    if ($urandom_range(0, 3) != 0) w[11:7] = 5'd0;
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int fcnt[4];
    int c_pause, c_pred0, c_succ0;
    void'($urandom(32'd1234));
    fcnt = '{0, 0, 0, 0};
    c_pause = 0; c_pred0 = 0; c_succ0 = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid || is_nop || is_other) begin
      fails++;
      $display("FAIL R1 reset: valid %b, expected 0", out_valid);
    end
    rst = 1'b0;
    idle_check();

    // directed corners
    send(32'h0000_0013);                 // R3 canonical NOP
    send(32'h0010_0013);                 // R4 ADDI x0,x0,1
    send(32'h0000_8013);                 // R4 ADDI x0,x1,0
    send(32'h0020_8033);                 // R4 ADD x0,x1,x2 args
    send(32'h4020_8033);                 // R4 SUB
    send(32'h0020_A033);                 // R5 SLT
    send(32'h0050_A013);                 // R5 SLTI
    send(32'h4030_D013);                 // R5 SRAI
    send(32'h0200_1013);                 // R8 SLLI bad funct7
    send(32'h0020_80B3);                 // R8 ADD rd=x1
    send(32'h0100_000F);                 // R7 PAUSE
    send(32'h0000_000F);                 // R6 pred=succ=0
    send(32'h0FF0_000F);                 // R8 full fence
    send(32'h8330_000F);                 // R8 fm nonzero
    send(32'h0000_007F);                 // R8 unknown opcode
    idle_check();
    send(32'h12345037);                  // R4 LUI x0
    idle_check();

    // R6/R7 exhaustive fence sweep
    for (int fm = 0; fm < 16; fm++)
      for (int pr = 0; pr < 16; pr++)
        for (int sc = 0; sc < 16; sc++)
          for (int pat = 0; pat < 4; pat++) begin
            logic [31:0] w;
            w = {fm[3:0], pr[3:0], sc[3:0], (pat[1] ? 5'd17 : 5'd0), 3'd0,
                 (pat[0] ? 5'd9 : 5'd0), 7'h0F};
            send(w);
            if (is_fence_hint) begin
              fcnt[pat]++;
              if (pat == 0 && pr == 0 && sc != 0) c_pred0++;
              if (pat == 0 && sc == 0) c_succ0++;
            end
            if (is_pause) c_pause++;
          end
    expect_count("R6 rd-only form x31", fcnt[1] * 31, 1024 - 63);
    expect_count("R6 rs1-only form x31", fcnt[2] * 31, 1024 - 63);
    expect_count("R6 null pred", c_pred0, 15);
    expect_count("R6 null succ", c_succ0, 15);
    expect_count("R8 both regs nonzero", fcnt[3], 0);
    expect_count("R7 pause", c_pause, 1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      send(rand_word());
      if ((i % 97) == 0) idle_check();
    end
    idle_check();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule